// File: doc/BRIEF.md
# Background Stage-Weight Calibrator

This block is the digital back end of a pipelined converter made of four redundant 1.5-bit front stages and a 6-bit back-end quantizer. It builds the 12-bit output word from the raw stage codes. Every stage has two kinds of trimmable weight. The first is a gain weight that scales everything behind the stage. The second is a weight for each of the stage's three sub-DAC decisions. The word is built from the back-end code toward the front stage. At each step the partial result is multiplied by the stage gain, and the weight of the level that the stage picked is then added.

A slower, accurate reference converter samples the same input. Whenever its word is flagged valid, the block takes the difference between the reference and the rebuilt value as the error. It then nudges the weights that took part in that conversion, using a sign-free LMS step. The step is the error shifted right by a selectable amount. Conversion never stops while this happens. A freeze input stops learning and leaves the correction in place. All weights can be read back on two flat buses.

Top module: `stage_weight_cal`

## Requirements
- R1: A synchronous active-low reset sets the output word to 0 and every gain weight to 32768, which is 2.0 with 14 fraction bits. It sets the level weight of decision d in every stage to d*16384, which is d*64 output LSB with 8 fraction bits. Readback: gain of stage k sits at `gain_rd[18k+17:18k]`. Level d of stage k sits at `lvl_rd[(3k+d)*18 +: 18]`. All weights are signed 18-bit.
- R2: The value starts at the back-end code shifted left by 9. For each stage k from 3 down to 0, stage 0 being the front stage in `stg_code[1:0]` and stage k in `stg_code[2k+1:2k]`, the value becomes ((value*gain_k) >>> 14) + level_k[code_k]. `corr_word` is value >>> 8 and appears one clock after the inputs.
- R3: A stage code of 3 is treated as code 2.
- R4: When value >>> 8 is negative, `corr_word` is 0. When it exceeds 4095, `corr_word` is 4095.
- R5: When `ref_vld` is 1 and `cal_hold` is 0, the error is ref_word*256 minus the value of R2. The selected level weight of each stage gains error >>> (8+`mu_sel`). The sum saturates to the signed 18-bit range.
- R6: In such an update, the gain weight of a stage gets the same saturating step only if the partial value that enters that stage is nonzero. Otherwise the gain keeps its value.
- R7: The level weights that a stage did not select keep their values.
- R8: When `ref_vld` is 0, no weight changes, whatever the reference word is.
- R9: When `cal_hold` is 1, no weight changes, and the output stays corrected per R2 and R4.
- R10: The LMS shift is 8 plus the 3-bit `mu_sel`, which spans 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_code | input | 8 | Four 2-bit stage decisions, stage 0 (front) in the low bits |
| be_code | input | 6 | Back-end quantizer code |
| ref_word | input | 12 | Reference converter word for the same sample |
| ref_vld | input | 1 | Reference word is valid this cycle |
| cal_hold | input | 1 | Freeze weight learning |
| mu_sel | input | 3 | LMS step select, shift = 8 + mu_sel |
| corr_word | output | 12 | Corrected output word |
| gain_rd | output | 72 | Gain weights of all stages |
| lvl_rd | output | 216 | Level weights of all stages |

## Verification
A wrong weight shows up on the readback buses in the very clock after the update that produced it. On `corr_word` it shows up one clock later, but only for inputs whose codes select that weight. Each stage's gain can show up there only when a nonzero value enters that stage. A wrong update rule looks harmless in one cycle but compounds across cycles. For that reason the bench steps a behavioural model with the design on every clock and compares all 16 weights and the output each cycle, instead of only sampling at the end. The stimulus includes long learning runs, freeze windows and reference-invalid windows.

// File: rtl/calib_pkg.sv
// Shared fixed-point types and helpers for the stage-weight calibrator.
// Assumes: weights are signed WW-bit, gains carry FRAC_G fraction bits,
// levels and the running value carry FRAC_L fraction bits.
package calib_pkg;
    localparam int WW     = 18;
    localparam int FRAC_G = 14;
    localparam int FRAC_L = 8;
    localparam int ACC_W  = 40;
    localparam int NLVL   = 3;

    typedef logic signed [WW-1:0]    wt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    localparam wt_t    GAIN_NOM = wt_t'(2 << FRAC_G);
    localparam longint W_MAXL   = (longint'(1) << (WW - 1)) - 1;
    localparam longint W_MINL   = -(longint'(1) << (WW - 1));

    // Add a wide step to a weight and saturate to the weight range.
    function automatic wt_t sat_add(wt_t w, acc_t step);
        acc_t s;
        s = acc_t'(w) + step;
        if (s > acc_t'(W_MAXL))
            return wt_t'(W_MAXL);
        else if (s < acc_t'(W_MINL))
            return wt_t'(W_MINL);
        else
            return wt_t'(s);
    endfunction
endpackage

// File: rtl/stg_rebuild.sv
// One nesting step of the output rebuild: scales the partial value coming
// from the stages behind by this stage's gain and adds the chosen level.
// Assumes: purely combinational, values stay inside ACC_W bits.
module stg_rebuild
    import calib_pkg::*;
(
    input  acc_t part_in,
    input  wt_t  gain,
    input  wt_t  lvl,
    output acc_t part_out
);
    localparam int PROD_W = ACC_W + WW;

    logic signed [PROD_W-1:0] prod;

    // Multiply by the gain, drop gain fraction bits, add level weight.
    always_comb begin
        prod     = PROD_W'(part_in) * PROD_W'(gain);
        part_out = ACC_W'(prod >>> FRAC_G) + ACC_W'(lvl);
    end
endmodule

// File: rtl/wt_bank.sv
// Weight store of one 1.5-bit stage: one gain and three level weights.
// On an update it moves the selected level, and it moves the gain only
// when the value entering the stage is nonzero.
// Assumes: code 3 never comes from a healthy stage and is folded onto 2.
module wt_bank
    import calib_pkg::*;
#(
    parameter wt_t LVL_STEP = wt_t'(16384)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        code,
    input  acc_t              part_in,
    input  acc_t              step,
    output wt_t               gain_o,
    output wt_t               lvl_sel_o,
    output logic [NLVL*WW-1:0] lvl_flat
);
    wt_t        lvl_q [NLVL];
    wt_t        gain_q;
    logic [1:0] sel;

    // Fold the illegal code onto the top decision.
    always_comb sel = (code == 2'd3) ? 2'd2 : code;

    // Reset to nominal weights, then apply LMS steps when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= GAIN_NOM;
            for (int i = 0; i < NLVL; i++)
                lvl_q[i] <= LVL_STEP * wt_t'(i);
        end else if (upd_en) begin
            lvl_q[sel] <= sat_add(lvl_q[sel], step);
            if (part_in != '0)
                gain_q <= sat_add(gain_q, step);
        end
    end

    assign gain_o    = gain_q;
    assign lvl_sel_o = lvl_q[sel];

    for (genvar i = 0; i < NLVL; i++) begin : g_rd
        assign lvl_flat[i*WW +: WW] = lvl_q[i];
    end

    AST_ONE_LEVEL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0({lvl_q[0] != $past(lvl_q[0]),
                                   lvl_q[1] != $past(lvl_q[1]),
                                   lvl_q[2] != $past(lvl_q[2])})); // R7

    AST_GAIN_IDLE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(part_in == '0)) |-> $stable(gain_q)); // R6
endmodule

// File: rtl/stage_weight_cal.sv
// Background stage-weight calibrator, top level.
// Rebuilds the corrected word from stage codes through a chain of
// stg_rebuild steps and, on a valid reference word, feeds the shifted
// error to every stage's wt_bank. Output is registered (one clock).
// Assumes: ref_word belongs to the same sample as the codes in that cycle.
module stage_weight_cal
    import calib_pkg::*;
#(
    parameter int NSTG    = 4,
    parameter int BE_W    = 6,
    parameter int OUT_W   = 12,
    parameter int SH_W    = 3,
    parameter int SH_BASE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*NSTG-1:0]       stg_code,
    input  logic [BE_W-1:0]         be_code,
    input  logic [OUT_W-1:0]        ref_word,
    input  logic                    ref_vld,
    input  logic                    cal_hold,
    input  logic [SH_W-1:0]         mu_sel,
    output logic [OUT_W-1:0]        corr_word,
    output logic [NSTG*WW-1:0]      gain_rd,
    output logic [NSTG*NLVL*WW-1:0] lvl_rd
);
    localparam int  BE_SH   = OUT_W - BE_W - NSTG - 1;
    localparam int  LVL_LSB = 1 << (OUT_W - NSTG - 2);
    localparam wt_t LVL_STP = wt_t'(LVL_LSB << FRAC_L);
    localparam int  OUT_MAX = (1 << OUT_W) - 1;

    acc_t            be_val;
    acc_t            p_in  [NSTG];
    acc_t            p_out [NSTG];
    wt_t             gain_w [NSTG];
    wt_t             lvl_w  [NSTG];
    acc_t            err;
    acc_t            step;
    acc_t            res;
    logic            upd_en;
    logic [OUT_W-1:0] out_d;
    logic [OUT_W-1:0] corr_q;

    // Back-end code aligned to the output scale with level fraction bits.
    always_comb be_val = acc_t'(be_code) <<< (FRAC_L + BE_SH);

    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        if (k == NSTG - 1) begin : g_last
            assign p_in[k] = be_val;
        end else begin : g_mid
            assign p_in[k] = p_out[k+1];
        end

        stg_rebuild u_rb (
            .part_in  (p_in[k]),
            .gain     (gain_w[k]),
            .lvl      (lvl_w[k]),
            .part_out (p_out[k])
        );

        wt_bank #(.LVL_STEP(LVL_STP)) u_wb (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en    (upd_en),
            .code      (stg_code[2*k +: 2]),
            .part_in   (p_in[k]),
            .step      (step),
            .gain_o    (gain_w[k]),
            .lvl_sel_o (lvl_w[k]),
            .lvl_flat  (lvl_rd[k*NLVL*WW +: NLVL*WW])
        );

        assign gain_rd[k*WW +: WW] = gain_w[k];
    end

    // Error against the reference and the LMS step derived from it.
    always_comb begin
        upd_en = ref_vld && !cal_hold;
        err    = (acc_t'(ref_word) <<< FRAC_L) - p_out[0];
        step   = err >>> (SH_BASE + int'(mu_sel));
    end

    // Drop fraction bits and clamp to the output range.
    always_comb begin
        res = p_out[0] >>> FRAC_L;
        if (res < 0)
            out_d = '0;
        else if (res > acc_t'(OUT_MAX))
            out_d = '1;
        else
            out_d = res[OUT_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr_q <= '0;
        else
            corr_q <= out_d;
    end

    assign corr_word = corr_q;

    AST_FROZEN_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cal_hold)) |-> ($stable(gain_rd) && $stable(lvl_rd))); // R9

    AST_FROZEN_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ref_vld)) |-> ($stable(gain_rd) && $stable(lvl_rd))); // R8

    AST_NEG_CLAMPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (p_out[0] < 0) |=> (corr_word == '0)); // R4
endmodule

// File: tb/stage_weight_cal_tb_top.sv
module stage_weight_cal_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int W  = 18;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  stg_code = '0;
    logic [5:0]  be_code = '0;
    logic [11:0] ref_word = '0;
    logic        ref_vld = 0;
    logic        cal_hold = 0;
    logic [2:0]  mu_sel = '0;
    logic [11:0] corr_word;
    logic [NS*W-1:0]   gain_rd;
    logic [NS*3*W-1:0] lvl_rd;

    int total = 0, bad = 0, cyc = 0;
    bit chk_en = 0, done = 0;
    string cur_tag = "R2";

    longint m_gain [NS];
    longint m_lvl  [NS][3];
    longint exp_corr = 0;
    int lo_seen = 0, hi_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stage_weight_cal dut_i (
        .clk(clk), .rst_n(rst_n), .stg_code(stg_code), .be_code(be_code),
        .ref_word(ref_word), .ref_vld(ref_vld), .cal_hold(cal_hold),
        .mu_sel(mu_sel), .corr_word(corr_word), .gain_rd(gain_rd), .lvl_rd(lvl_rd)
    );

    function automatic longint sat18(longint v);
        if (v > 131071) return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    task automatic check_eq(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint rd_gain(int k);
        return longint'($signed(gain_rd[k*W +: W]));
    endfunction

    function automatic longint rd_lvl(int k, int d);
        return longint'($signed(lvl_rd[(3*k+d)*W +: W]));
    endfunction

    // Behavioural reference model, stepped on every clock.
    always @(posedge clk) begin
        longint a, p, e, st, raw;
        longint part [NS+1];
        int sel [NS];
        int c;
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_gain[k] = 32768;
                for (int d = 0; d < 3; d++) m_lvl[k][d] = d * 16384;
            end
            exp_corr = 0;
        end else begin
            a = longint'(be_code) * 512;
            for (int k = NS-1; k >= 0; k--) begin
                c = int'(stg_code[2*k +: 2]);
                if (c == 3) c = 2;
                part[k+1] = a;
                sel[k] = c;
                p = a * m_gain[k];
                a = (p >>> 14) + m_lvl[k][c];
            end
            raw = a >>> 8;
            if (raw < 0) begin exp_corr = 0; lo_seen++; end
            else if (raw > 4095) begin exp_corr = 4095; hi_seen++; end
            else exp_corr = raw;
            if (ref_vld && !cal_hold) begin
                e  = longint'(ref_word) * 256 - a;
                st = e >>> (8 + int'(mu_sel));
                for (int k = 0; k < NS; k++) begin
                    m_lvl[k][sel[k]] = sat18(m_lvl[k][sel[k]] + st);
                    if (part[k+1] != 0) m_gain[k] = sat18(m_gain[k] + st);
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check_eq({cur_tag, " corr_word"}, longint'(corr_word), exp_corr);
            for (int k = 0; k < NS; k++) begin
                check_eq({cur_tag, " gain"}, rd_gain(k), m_gain[k]);
                for (int d = 0; d < 3; d++)
                    check_eq({cur_tag, " level"}, rd_lvl(k, d), m_lvl[k][d]);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic drive(logic [7:0] c, logic [5:0] b, logic [11:0] r,
                         logic v, logic h, logic [2:0] m);
        stg_code = c; be_code = b; ref_word = r; ref_vld = v; cal_hold = h; mu_sel = m;
        @(negedge clk);
    endtask

    task automatic do_reset();
        chk_en = 0;
        rst_n = 0;
        ref_vld = 0; cal_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_en = 1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset values seen directly after reset release
        cur_tag = "R1";
        check_eq("R1 corr after reset", longint'(corr_word), 0);
        for (int k = 0; k < NS; k++) begin
            check_eq("R1 gain nominal", rd_gain(k), 32768);
            for (int d = 0; d < 3; d++)
                check_eq("R1 level nominal", rd_lvl(k, d), d * 16384);
        end

        // R2: ideal rebuild with nominal weights
        cur_tag = "R2";
        drive(8'b10101010, 6'd63, 12'd0, 0, 0, 3'd0);
        check_eq("R2 full scale word", longint'(corr_word), 3936);
        drive(8'h00, 6'd0, 12'd0, 0, 0, 3'd0);
        check_eq("R2 zero word", longint'(corr_word), 0);
        drive(8'b00000001, 6'd10, 12'd0, 0, 0, 3'd0);
        check_eq("R2 mixed word", longint'(corr_word), 320 + 64);
        // R3: code 3 folds onto code 2
        cur_tag = "R3";
        drive(8'hFF, 6'd63, 12'd0, 0, 0, 3'd0);
        check_eq("R3 code3 as code2", longint'(corr_word), 3936);

        // R8: invalid reference leaves weights alone
        cur_tag = "R8";
        drive(8'h00, 6'd0, 12'd4000, 0, 0, 3'd0);
        check_eq("R8 level0 stays", rd_lvl(0, 0), 0);
        check_eq("R8 gain0 stays", rd_gain(0), 32768);

        // R9: hold freezes weights but output keeps correcting
        cur_tag = "R9";
        drive(8'b10101010, 6'd63, 12'd100, 1, 1, 3'd0);
        check_eq("R9 level2 frozen", rd_lvl(0, 2), 32768);
        check_eq("R9 output still corrected", longint'(corr_word), 3936);

        // R5/R6/R7: one learning step with zero partials
        cur_tag = "R5";
        drive(8'h00, 6'd0, 12'd100, 1, 0, 3'd0);
        for (int k = 0; k < NS; k++) begin
            check_eq("R5 level0 step", rd_lvl(k, 0), 100);
            check_eq("R6 gain idle zero partial", rd_gain(k), 32768);
            check_eq("R7 level1 untouched", rd_lvl(k, 1), 16384);
            check_eq("R7 level2 untouched", rd_lvl(k, 2), 32768);
        end
        // R6: second step, partials nonzero except into stage 3
        cur_tag = "R6";
        drive(8'h00, 6'd0, 12'd100, 1, 0, 3'd0);
        check_eq("R6 gain3 idle", rd_gain(3), 32768);
        for (int k = 0; k < 3; k++)
            check_eq("R6 gain moves", rd_gain(k), 32862);
        check_eq("R5 level0 second step", rd_lvl(0, 0), 194);

        // R10: largest shift
        do_reset();
        cur_tag = "R10";
        drive(8'h00, 6'd0, 12'd4095, 1, 0, 3'd7);
        check_eq("R10 shift15 step", rd_lvl(2, 0), 31);
        drive(8'h00, 6'd0, 12'd4095, 0, 0, 3'd0);

        // R4: low clamp after negative learning
        do_reset();
        cur_tag = "R4";
        drive(8'h00, 6'd63, 12'd0, 1, 0, 3'd0);
        check_eq("R4 learned level0", rd_lvl(1, 0), -2016);
        lo_seen = 0;
        drive(8'h00, 6'd0, 12'd0, 0, 0, 3'd0);
        drive(8'h00, 6'd0, 12'd0, 0, 0, 3'd0);
        check_eq("R4 low clamp value", longint'(corr_word), 0);
        check_eq("R4 low clamp reached", longint'(lo_seen > 0), 1);

        // R4: high clamp after upward learning
        do_reset();
        for (int i = 0; i < 600; i++) drive(8'h00, 6'd0, 12'd4095, 1, 0, 3'd2);
        hi_seen = 0;
        drive(8'h00, 6'd63, 12'd0, 0, 0, 3'd0);
        drive(8'h00, 6'd63, 12'd0, 0, 0, 3'd0);
        check_eq("R4 high clamp value", longint'(corr_word), 4095);
        check_eq("R4 high clamp reached", longint'(hi_seen > 0), 1);

        // R2/R5/R8/R9: long mixed run against the model
        do_reset();
        cur_tag = "R2 random";
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            drive(c, 6'($urandom), 12'($urandom), 1'($urandom),
                  ($urandom % 4) == 0, 3'(4 + ($urandom % 4)));
        end
        finish_run();
    end
endmodule